// File: doc/BRIEF.md
# Dead-time linearizing pixel accumulator

This block is the digital controller of a single-photon pixel. A time-to-digital converter delivers zero or more timestamps during each arm period, and a global arm pulse opens every period. The block keeps only the timestamps that are ordered within the current arm period. The surviving set matches what a detector with no dead time would produce. No histogram is stored. Per phase, only an event count and a running timestamp sum are kept.

A host frame start clears all results and runs two acquisition phases back to back. The first collects background with the laser held off. The second collects signal plus background with the laser on, driven from the `laserEn` output. A phase ends when its count reaches a programmed target or when a programmed number of arm pulses has passed.

Two ordering schemes are offered. In discard mode, an out-of-order timestamp is dropped. In gated mode, the last accepted timestamp is also presented as a re-arm delay for the front end. At the end, the host reads the two counts and the two sums and computes the range from them.

Top module: `pixelLinAccum`

## Requirements
- R1: After a frame start the phase sequence is background (`laserEn`=0, `done`=0), then signal (`laserEn`=1), then finished (`done`=1, `laserEn`=0); `laserEn` and `done` are never high together.
- R2: An accepted timestamp adds 1 to the active phase's count and its value to that phase's sum, visible one cycle after it is presented; the other phase's registers do not change.
- R3: The active phase ends when its count is at or above `countTarget`; during the cycle in which the count has reached the target, an incoming timestamp is ignored and the next phase starts on the following edge (a target of 0 ends the phase with no events).
- R4: The active phase also ends once the number of arm pulses seen in that phase is at or above `timeoutArms`; a timestamp in the ending cycle is ignored.
- R5: Within an arm period a timestamp smaller than the last accepted one is discarded; an equal or larger one is accepted.
- R6: An arm pulse clears the last accepted timestamp to 0; a timestamp arriving in the same cycle as an arm pulse is compared against 0 and is therefore always accepted.
- R7: With `gatedMode`=1, `gateDelay` equals the last accepted timestamp of the current arm period (0 after an arm pulse); with `gatedMode`=0, `gateDelay` is 0.
- R8: Reset, and a `frameStart` pulse one cycle earlier, leave both counts and sums at 0, `ovf`=0, `done`=0 and `laserEn`=0, with the background phase running after `frameStart`.
- R9: Counts and sums saturate at full scale (0xFFFF, 0xFFFFFF) instead of wrapping, and `ovf` goes high and stays high until the next frame start.
- R10: Once finished, `done` holds and timestamps are ignored until the next `frameStart`.
- R11: A phase change clears the last accepted timestamp, so the first timestamp of the signal phase is always accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| frameStart | input | 1 | Host pulse: clear results and begin background phase |
| armPulse | input | 1 | Start of a new arm period |
| tsValid | input | 1 | Timestamp strobe |
| tsValue | input | 12 | Timestamp, one LSB per converter step |
| gatedMode | input | 1 | 0 = discard scheme, 1 = gated scheme |
| countTarget | input | 16 | Events that end a phase |
| timeoutArms | input | 16 | Arm pulses that end a phase |
| laserEn | output | 1 | High during the signal phase |
| gateDelay | output | 12 | Re-arm delay for the front end in gated mode |
| bgCount | output | 16 | Background phase event count |
| bgSum | output | 24 | Background phase timestamp sum |
| sigCount | output | 16 | Signal phase event count |
| sigSum | output | 24 | Signal phase timestamp sum |
| ovf | output | 1 | Sticky saturation flag |
| done | output | 1 | Both phases finished |

## Verification
The hardest state to reach from the ports is sum saturation. A sum overflow needs more than four thousand maximum-value timestamps inside a single phase. The stimulus sets the target and the time-out to full scale, keeps arm pulses away, and streams equal full-scale timestamps so that none is discarded. The exact threshold is then checked: no overflow after 4097 events, and saturation with a sticky flag on the 4098th. The single-cycle window after a target is reached is also hard to hit. It is reached by presenting a timestamp in exactly that cycle and confirming that the timestamp lands in neither phase.

// File: rtl/pla_pkg.sv
package pla_pkg;
  typedef enum logic [1:0] {PH_IDLE, PH_BG, PH_SIG, PH_DONE} phase_e;

  typedef struct packed {
    logic clearAll;
    logic acceptEn;
    logic bankSel;
    logic lastClr;
  } dpStrobe_t;
endpackage

// File: rtl/pla_ctrl.sv
module pla_ctrl
  import pla_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int ARM_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             frameStart,
  input  logic             armPulse,
  input  logic [CNT_W-1:0] countTarget,
  input  logic [ARM_W-1:0] timeoutArms,
  input  logic [CNT_W-1:0] curCount,
  output dpStrobe_t        strobe,
  output phase_e           phase
);
  localparam logic [ARM_W-1:0] ARM_MAX = {ARM_W{1'b1}};

  logic [ARM_W-1:0] armCnt;
  logic             active;
  logic             endNow;
  phase_e           nextPhase;

  assign active = (phase == PH_BG) || (phase == PH_SIG);
  assign endNow = active && ((curCount >= countTarget) || (armCnt >= timeoutArms));

  always_comb begin
    case (phase)
      PH_BG:   nextPhase = PH_SIG;
      PH_SIG:  nextPhase = PH_DONE;
      default: nextPhase = phase;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase  <= PH_IDLE;
      armCnt <= '0;
    end else if (frameStart) begin
      phase  <= PH_BG;
      armCnt <= '0;
    end else if (endNow) begin
      phase  <= nextPhase;
      armCnt <= '0;
    end else if (active && armPulse && (armCnt != ARM_MAX)) begin
      armCnt <= armCnt + 1'b1;
    end
  end

  always_comb begin
    strobe.clearAll = frameStart;
    strobe.acceptEn = active && !endNow && !frameStart;
    strobe.bankSel  = (phase == PH_SIG);
    strobe.lastClr  = armPulse || endNow || frameStart;
  end
endmodule

// File: rtl/pla_datapath.sv
module pla_datapath
  import pla_pkg::*;
#(
  parameter int TS_W  = 12,
  parameter int CNT_W = 16,
  parameter int SUM_W = 24
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        strobe,
  input  logic             tsValid,
  input  logic [TS_W-1:0]  tsValue,
  input  logic             gatedMode,
  output logic [CNT_W-1:0] bankCount [2],
  output logic [SUM_W-1:0] bankSum   [2],
  output logic [CNT_W-1:0] curCount,
  output logic [TS_W-1:0]  gateDelay,
  output logic             ovf
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [SUM_W-1:0] SUM_MAX = {SUM_W{1'b1}};
  localparam int               PAD_W   = SUM_W - TS_W;

  logic [TS_W-1:0] lastTs;
  logic [TS_W-1:0] refTs;
  logic            accept;
  logic [1:0]      bankOvf;

  assign refTs  = strobe.lastClr ? '0 : lastTs;
  assign accept = strobe.acceptEn && tsValid && (tsValue >= refTs);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               lastTs <= '0;
    else if (accept)         lastTs <= tsValue;
    else if (strobe.lastClr) lastTs <= '0;
  end

  for (genvar g = 0; g < 2; g++) begin : gBank
    localparam logic MY_SEL = (g == 1);
    logic [SUM_W:0] sumWide;
    logic           hit;

    assign sumWide = {1'b0, bankSum[g]} + {1'b0, {PAD_W{1'b0}}, tsValue};
    assign hit     = accept && (strobe.bankSel == MY_SEL);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        bankCount[g] <= '0;
        bankSum[g]   <= '0;
        bankOvf[g]   <= 1'b0;
      end else if (strobe.clearAll) begin
        bankCount[g] <= '0;
        bankSum[g]   <= '0;
        bankOvf[g]   <= 1'b0;
      end else if (hit) begin
        if (bankCount[g] == CNT_MAX) bankOvf[g] <= 1'b1;
        else                         bankCount[g] <= bankCount[g] + 1'b1;
        if (sumWide[SUM_W]) begin
          bankSum[g] <= SUM_MAX;
          bankOvf[g] <= 1'b1;
        end else begin
          bankSum[g] <= sumWide[SUM_W-1:0];
        end
      end
    end
  end

  assign curCount  = strobe.bankSel ? bankCount[1] : bankCount[0];
  assign gateDelay = gatedMode ? lastTs : '0;
  assign ovf       = |bankOvf;
endmodule

// File: rtl/pixelLinAccum.sv
module pixelLinAccum
  import pla_pkg::*;
#(
  parameter int TS_W  = 12,
  parameter int CNT_W = 16,
  parameter int SUM_W = 24,
  parameter int ARM_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             frameStart,
  input  logic             armPulse,
  input  logic             tsValid,
  input  logic [TS_W-1:0]  tsValue,
  input  logic             gatedMode,
  input  logic [CNT_W-1:0] countTarget,
  input  logic [ARM_W-1:0] timeoutArms,
  output logic             laserEn,
  output logic [TS_W-1:0]  gateDelay,
  output logic [CNT_W-1:0] bgCount,
  output logic [SUM_W-1:0] bgSum,
  output logic [CNT_W-1:0] sigCount,
  output logic [SUM_W-1:0] sigSum,
  output logic             ovf,
  output logic             done
);
  dpStrobe_t        strobe;
  phase_e           phase;
  logic [CNT_W-1:0] curCount;
  logic [CNT_W-1:0] bankCount [2];
  logic [SUM_W-1:0] bankSum   [2];

  pla_ctrl #(.CNT_W(CNT_W), .ARM_W(ARM_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .frameStart(frameStart), .armPulse(armPulse),
    .countTarget(countTarget), .timeoutArms(timeoutArms), .curCount(curCount),
    .strobe(strobe), .phase(phase)
  );

  pla_datapath #(.TS_W(TS_W), .CNT_W(CNT_W), .SUM_W(SUM_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .tsValid(tsValid), .tsValue(tsValue),
    .gatedMode(gatedMode), .bankCount(bankCount), .bankSum(bankSum),
    .curCount(curCount), .gateDelay(gateDelay), .ovf(ovf)
  );

  assign laserEn  = (phase == PH_SIG);
  assign done     = (phase == PH_DONE);
  assign bgCount  = bankCount[0];
  assign bgSum    = bankSum[0];
  assign sigCount = bankCount[1];
  assign sigSum   = bankSum[1];
endmodule

// File: rtl/pla_checker.sv
module pla_checker #(
  parameter int TS_W  = 12,
  parameter int CNT_W = 16,
  parameter int SUM_W = 24
) (
  input logic             clk,
  input logic             rstN,
  input logic             frameStart,
  input logic             armPulse,
  input logic             tsValid,
  input logic             gatedMode,
  input logic             laserEn,
  input logic             done,
  input logic             ovf,
  input logic [TS_W-1:0]  gateDelay,
  input logic [CNT_W-1:0] bgCount,
  input logic [SUM_W-1:0] bgSum,
  input logic [CNT_W-1:0] sigCount,
  input logic [SUM_W-1:0] sigSum
);
  a_r1_excl: assert property (@(posedge clk) disable iff (!rstN) !(laserEn && done));

  a_r1_order: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> $past(laserEn));

  a_r2_bg_mono: assert property (@(posedge clk) disable iff (!rstN)
    !frameStart |=> (bgSum >= $past(bgSum)));

  a_r2_sig_mono: assert property (@(posedge clk) disable iff (!rstN)
    !frameStart |=> (sigSum >= $past(sigSum)));

  a_r2_needs_valid: assert property (@(posedge clk) disable iff (!rstN)
    ((bgCount != $past(bgCount)) && !$past(frameStart)) |-> $past(tsValid));

  a_r7_gate_arm: assert property (@(posedge clk) disable iff (!rstN)
    (gatedMode && $past(armPulse) && !$past(tsValid)) |-> (gateDelay == '0));

  a_r8_frame_clear: assert property (@(posedge clk) disable iff (!rstN)
    $past(frameStart) |-> (bgCount == '0 && sigCount == '0 && bgSum == '0
                           && sigSum == '0 && !ovf && !done && !laserEn));

  a_r9_ovf_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (ovf && !frameStart) |=> ovf);

  a_r10_done_hold: assert property (@(posedge clk) disable iff (!rstN)
    (done && !frameStart) |=> done);
endmodule

bind pixelLinAccum pla_checker #(.TS_W(TS_W), .CNT_W(CNT_W), .SUM_W(SUM_W)) u_chk (
  .clk(clk), .rstN(rstN), .frameStart(frameStart), .armPulse(armPulse),
  .tsValid(tsValid), .gatedMode(gatedMode), .laserEn(laserEn), .done(done),
  .ovf(ovf), .gateDelay(gateDelay), .bgCount(bgCount), .bgSum(bgSum),
  .sigCount(sigCount), .sigSum(sigSum)
);

// File: tb/pixelLinAccum_bench.sv
`timescale 1ns/1ps
module pixelLinAccum_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        frameStart = 1'b0;
  logic        armPulse = 1'b0;
  logic        tsValid = 1'b0;
  logic [11:0] tsValue = '0;
  logic        gatedMode = 1'b0;
  logic [15:0] countTarget = 16'd5;
  logic [15:0] timeoutArms = 16'd100;
  logic        laserEn, ovf, done;
  logic [11:0] gateDelay;
  logic [15:0] bgCount, sigCount;
  logic [23:0] bgSum, sigSum;

  int checks = 0;
  int fails = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  pixelLinAccum u_pixelLinAccum (
    .clk(clk), .rstN(rstN), .frameStart(frameStart), .armPulse(armPulse),
    .tsValid(tsValid), .tsValue(tsValue), .gatedMode(gatedMode),
    .countTarget(countTarget), .timeoutArms(timeoutArms), .laserEn(laserEn),
    .gateDelay(gateDelay), .bgCount(bgCount), .bgSum(bgSum), .sigCount(sigCount),
    .sigSum(sigSum), .ovf(ovf), .done(done)
  );

  task automatic check(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference: 0 idle, 1 background, 2 signal, 3 finished
  int mPh = 0;
  int mCnt[2] = '{0, 0};
  int mSum[2] = '{0, 0};
  int mLast = 0;
  int mArms = 0;
  bit mOvf = 0;

  always @(posedge clk) begin
    if (!rstN) begin
      mPh = 0; mCnt = '{0, 0}; mSum = '{0, 0}; mLast = 0; mArms = 0; mOvf = 0;
    end else if (frameStart) begin
      mPh = 1; mCnt = '{0, 0}; mSum = '{0, 0}; mLast = 0; mArms = 0; mOvf = 0;
    end else begin
      bit act;
      bit finish;
      int b;
      int lim;
      act = (mPh == 1) || (mPh == 2);
      b = act ? mPh - 1 : 0;
      finish = act && ((mCnt[b] >= int'(countTarget)) || (mArms >= int'(timeoutArms)));
      lim = armPulse ? 0 : mLast;
      if (finish) begin
        mPh = mPh + 1; mArms = 0; mLast = 0;
      end else begin
        if (act && tsValid && int'(tsValue) >= lim) begin
          if (mCnt[b] == 65535) mOvf = 1; else mCnt[b] = mCnt[b] + 1;
          if (mSum[b] + int'(tsValue) > 16777215) begin
            mSum[b] = 16777215; mOvf = 1;
          end else mSum[b] = mSum[b] + int'(tsValue);
          mLast = int'(tsValue);
        end else if (armPulse) mLast = 0;
        if (act && armPulse && mArms < 65535) mArms = mArms + 1;
      end
    end
  end

  // Compare every clock, after the edge has settled
  always @(posedge clk) begin
    #2;
    check("R2 bgCount", bgCount, mCnt[0]);
    check("R2 bgSum", bgSum, mSum[0]);
    check("R2 sigCount", sigCount, mCnt[1]);
    check("R2 sigSum", sigSum, mSum[1]);
    check("R1 laserEn", laserEn, mPh == 2);
    check("R10 done", done, mPh == 3);
    check("R9 ovf", ovf, mOvf);
    check("R7 gateDelay", gateDelay, gatedMode ? mLast : 0);
  end

  task automatic cyc(input bit a, input bit v, input int t);
    armPulse = a; tsValid = v; tsValue = 12'(t);
    @(negedge clk);
    armPulse = 0; tsValid = 0; tsValue = '0;
  endtask

  task automatic frame();
    frameStart = 1;
    @(negedge clk);
    frameStart = 0;
  endtask

  initial begin
    while (cycles < 200000) begin
      @(posedge clk);
      cycles++;
    end
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R8 reset bgCount", bgCount, 0);
    check("R8 reset done", done, 0);
    check("R8 reset laserEn", laserEn, 0);
    rstN = 1;
    @(negedge clk);

    // Directed frame in discard mode
    countTarget = 5; timeoutArms = 100; gatedMode = 0;
    frame();
    check("R8 bg phase running", laserEn, 0);
    cyc(1, 0, 0);
    cyc(0, 1, 100);
    cyc(0, 1, 50);
    cyc(0, 1, 100);
    check("R5 drop smaller keep equal count", bgCount, 2);
    check("R5 drop smaller keep equal sum", bgSum, 200);
    cyc(0, 1, 200);
    cyc(1, 1, 10);
    check("R6 ts with arm accepted", bgCount, 4);
    check("R6 sum after arm", bgSum, 410);
    cyc(1, 0, 0);
    cyc(0, 1, 5);
    cyc(0, 1, 7);
    check("R3 ts in end cycle ignored bg", bgCount, 5);
    check("R3 bg sum frozen", bgSum, 415);
    check("R3 ts in end cycle ignored sig", sigCount, 0);
    check("R1 signal phase laser on", laserEn, 1);
    cyc(0, 1, 1);
    check("R11 first sig ts accepted", sigCount, 1);
    gatedMode = 1;
    cyc(0, 1, 300);
    check("R7 gated delay follows ts", gateDelay, 300);
    cyc(0, 1, 250);
    check("R7 gated delay holds", gateDelay, 300);
    check("R5 smaller dropped sig", sigCount, 2);
    cyc(1, 0, 0);
    check("R6 arm clears gate", gateDelay, 0);
    cyc(0, 1, 20);
    cyc(0, 1, 30);
    cyc(0, 1, 40);
    cyc(0, 0, 0);
    check("R1 done after signal", done, 1);
    check("R1 laser off at end", laserEn, 0);
    check("R2 sig sum", sigSum, 391);
    cyc(0, 1, 55);
    check("R10 ignored after done", sigCount, 5);
    gatedMode = 0;
    @(negedge clk);
    check("R7 discard mode gate zero", gateDelay, 0);

    // Time-out ends the phase
    countTarget = 1000; timeoutArms = 3;
    frame();
    cyc(1, 1, 10);
    cyc(1, 1, 10);
    cyc(1, 1, 10);
    cyc(0, 1, 9);
    check("R4 timeout ends bg", laserEn, 1);
    check("R4 end cycle ts ignored", bgCount, 3);
    cyc(0, 1, 8);
    frame();
    check("R8 frame start clears sig", sigCount, 0);
    check("R8 frame start clears bg", bgSum, 0);
    check("R8 back to background", laserEn, 0);

    // Zero target
    countTarget = 0;
    frame();
    cyc(0, 1, 5);
    check("R3 zero target no event", bgCount, 0);
    cyc(0, 1, 5);
    check("R3 zero target finishes", done, 1);

    // Random streams, both modes
    for (int f = 0; f < 6; f++) begin
      countTarget = 16'(20 + 7 * f);
      timeoutArms = 16'(15 + f);
      gatedMode = f[0];
      frame();
      for (int i = 0; i < 300; i++) begin
        cyc(($urandom % 8) == 0, ($urandom % 2) == 0, int'($urandom % 4096));
      end
    end

    // Saturation of the sum
    countTarget = 16'hFFFF; timeoutArms = 16'hFFFF; gatedMode = 0;
    frame();
    for (int i = 0; i < 4097; i++) cyc(0, 1, 4095);
    check("R9 sum at full scale", bgSum, 16777215);
    check("R9 no overflow yet", ovf, 0);
    cyc(0, 1, 4095);
    check("R9 sum saturates", bgSum, 16777215);
    check("R9 overflow set", ovf, 1);
    check("R9 count keeps counting", bgCount, 4098);
    cyc(0, 0, 0);
    check("R9 overflow sticky", ovf, 1);
    frame();
    check("R8 overflow cleared", ovf, 0);

    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule